// File: doc/BRIEF.md
# Shared Coefficient Quantizer and Dequantizer

This block takes the integer-transform coefficients of the chosen prediction mode and does two jobs in one pass. It produces the quantized levels that the entropy coder needs. From those same levels it also produces the dequantized coefficients that the reconstruction path feeds into the inverse transform. One instance serves both consumers at once, so the design needs no second quantizer and no ping-pong copy of the block.

Coefficients arrive eight per beat on a valid/ready stream. Each block is either a 4x4 block of 2 beats or an 8x8 block of 8 beats, and a flag chooses the size block by block. A start-of-block marker on the first beat captures the quantization parameter, the size and the rounding flavour, and those settings hold for the rest of the block. The levels and the dequantized values leave on two independent valid/ready streams. The pipeline moves on only when both streams have taken the current beat.

Top module: `quantdq`

## Requirements
- R1: While reset is asserted and at the first sample after it is released, `lvl_valid` and `dq_valid` are 0 and `in_ready` is 1.
- R2: `in_qp` is in the range 0..51 and is split into a shift part qp/6 and a row part qp%6. The multiplier MF and the scale V come from the standard H.264 flat-matrix tables, indexed by qp%6 and by position class. For 4x4 the classes are: class 0 when row and column are both even, class 1 when both are odd, class 2 otherwise. For 8x8 the classes are, in priority order: class 0 when row%4=0 and col%4=0; class 1 when both are odd; class 2 when row%4=2 and col%4=2; class 3 when one index is 0 mod 4 and the other is odd; class 4 when one index is 0 mod 4 and the other is 2 mod 4; class 5 otherwise.
- R3: Lane l (0..7) of a beat sits at bits [16l+15:16l] of `in_coef` and at the same lane slice of each output. In a 4x4 block, beat b, lane l is row 2b+l/4, column l%4. In an 8x8 block, beat b, lane l is row b, column l.
- R4: The level is sign(c)*((|c|*MF + off) >> qb). qb is 15+qp/6 for 4x4 and 16+qp/6 for 8x8. off is floor(2^qb/3) when `in_intra`=1 and floor(2^qb/6) otherwise. A zero input gives level 0. The step therefore doubles for every 6 steps of qp.
- R5: For a 4x4 block the dequantized value is (level*V) << (qp/6).
- R6: For an 8x8 block with qp/6 >= 2 the dequantized value is (level*V) << (qp/6-2). With qp/6 < 2 it is (level*V + 2^(1-qp/6)) arithmetically shifted right by 2-qp/6.
- R7: Values of `in_qp`, `in_is8x8` and `in_intra` on beats with `in_sop`=0 are ignored. The settings captured with `in_sop`=1 apply to every beat of that block.
- R8: Each accepted input beat yields exactly one beat on the level stream and one on the dequant stream, in input order.
- R9: An output beat that is valid but not accepted stays valid with unchanged data in the next cycle.
- R10: `in_ready` is 0 whenever either output stream holds a valid beat that its consumer is not accepting.
- R11: Whenever both output streams are valid, every lane's dequantized value is zero exactly when its level is zero, and otherwise has the same sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with valid |
| in_sop | input | 1 | Marks the first beat of a block |
| in_qp | input | QPW | Quantization parameter, sampled on the first beat |
| in_is8x8 | input | 1 | 1 = 8x8 block, 0 = 4x4 block, sampled on the first beat |
| in_intra | input | 1 | Selects the larger rounding offset, sampled on the first beat |
| in_coef | input | 8*CW | Eight signed coefficients |
| lvl_valid | output | 1 | Level beat valid |
| lvl_ready | input | 1 | Entropy side accepts a level beat |
| lvl_data | output | 8*LW | Eight signed quantized levels |
| dq_valid | output | 1 | Dequantized beat valid |
| dq_ready | input | 1 | Reconstruction side accepts a beat |
| dq_data | output | 8*DW | Eight signed dequantized coefficients |

## Verification
The properties assume that `in_qp` never exceeds 51 on a valid beat and that `in_sop` is raised on exactly the first beat of each block. The sign agreement check also relies on both output flags being set by the same accepted beat. The stimulus builds every block with a start marker on beat 0 only. It draws every parameter, including the garbage parameters driven on later beats, from 0..51. Separate stall phases hold each consumer's ready low so that back-pressure from either side is exercised.

// File: rtl/qd_pkg.sv
package qd_pkg;

    localparam int QD_LANES = 8;

    // forward multipliers, [qp%6][class]
    localparam logic [14:0] QD_MF4 [6][3] = '{
        '{15'd13107, 15'd5243, 15'd8066},
        '{15'd11916, 15'd4660, 15'd7490},
        '{15'd10082, 15'd4194, 15'd6554},
        '{15'd9362,  15'd3647, 15'd5825},
        '{15'd8192,  15'd3355, 15'd5243},
        '{15'd7282,  15'd2893, 15'd4559}
    };
    localparam logic [5:0] QD_V4 [6][3] = '{
        '{6'd10, 6'd16, 6'd13},
        '{6'd11, 6'd18, 6'd14},
        '{6'd13, 6'd20, 6'd16},
        '{6'd14, 6'd23, 6'd18},
        '{6'd16, 6'd25, 6'd20},
        '{6'd18, 6'd29, 6'd23}
    };
    localparam logic [14:0] QD_MF8 [6][6] = '{
        '{15'd13107, 15'd11428, 15'd20972, 15'd12222, 15'd16777, 15'd15481},
        '{15'd11916, 15'd10826, 15'd19174, 15'd11058, 15'd14980, 15'd14290},
        '{15'd10082, 15'd8943,  15'd15978, 15'd9675,  15'd12710, 15'd11985},
        '{15'd9362,  15'd8228,  15'd14913, 15'd8931,  15'd11984, 15'd11259},
        '{15'd8192,  15'd7346,  15'd13159, 15'd7740,  15'd10486, 15'd9777},
        '{15'd7282,  15'd6428,  15'd11570, 15'd6830,  15'd9118,  15'd8640}
    };
    localparam logic [5:0] QD_V8 [6][6] = '{
        '{6'd20, 6'd18, 6'd32, 6'd19, 6'd25, 6'd24},
        '{6'd22, 6'd19, 6'd35, 6'd21, 6'd28, 6'd26},
        '{6'd26, 6'd23, 6'd42, 6'd24, 6'd33, 6'd31},
        '{6'd28, 6'd25, 6'd45, 6'd26, 6'd35, 6'd33},
        '{6'd32, 6'd28, 6'd51, 6'd30, 6'd40, 6'd38},
        '{6'd36, 6'd32, 6'd58, 6'd34, 6'd46, 6'd43}
    };

    function automatic logic [2:0] qd_class4(logic [2:0] row, logic [2:0] col);
        if (!row[0] && !col[0])     return 3'd0;
        else if (row[0] && col[0])  return 3'd1;
        else                        return 3'd2;
    endfunction

    function automatic logic [2:0] qd_class8(logic [2:0] row, logic [2:0] col);
        logic r0, c0, r2, c2;
        r0 = (row[1:0] == 2'd0);
        c0 = (col[1:0] == 2'd0);
        r2 = (row[1:0] == 2'd2);
        c2 = (col[1:0] == 2'd2);
        if (r0 && c0)                          return 3'd0;
        else if (row[0] && col[0])             return 3'd1;
        else if (r2 && c2)                     return 3'd2;
        else if ((r0 && col[0]) || (row[0] && c0)) return 3'd3;
        else if ((r0 && c2) || (r2 && c0))     return 3'd4;
        else                                   return 3'd5;
    endfunction

endpackage

// File: rtl/qd_qp_split.sv
module qd_qp_split #(
    parameter int QPW = 6
) (
    input  logic [QPW-1:0] qp,
    output logic [3:0]     qp_div,
    output logic [2:0]     qp_mod
);
    always_comb begin
        qp_div = 4'(qp / 6);
        qp_mod = 3'(qp % 6);
    end
endmodule

// File: rtl/qd_lane.sv
module qd_lane
    import qd_pkg::*;
#(
    parameter int CW = 16,
    parameter int LW = 16,
    parameter int DW = 32
) (
    input  logic [CW-1:0] coef,
    input  logic [2:0]    row,
    input  logic [2:0]    col,
    input  logic          is8,
    input  logic          intra,
    input  logic [3:0]    qp_div,
    input  logic [2:0]    qp_mod,
    output logic [LW-1:0] level,
    output logic [DW-1:0] dq
);
    localparam int PW = CW + 24;   // |c|*MF plus rounding offset
    localparam int XW = DW + 16;   // dequant product before shifting

    logic [2:0]           cls4, cls8;
    logic [14:0]          mf;
    logic [5:0]           vsc;
    logic [4:0]           qbits;
    logic                 neg;
    logic [CW:0]          absc;
    logic [PW-1:0]        one, off, prod;
    logic [LW-1:0]        mag;
    logic signed [XW-1:0] lv_ext, v_ext, scaled, rnd, res;

    always_comb begin
        cls4  = qd_class4(row, col);
        cls8  = qd_class8(row, col);
        mf    = is8 ? QD_MF8[qp_mod][cls8] : QD_MF4[qp_mod][cls4];
        vsc   = is8 ? QD_V8[qp_mod][cls8]  : QD_V4[qp_mod][cls4];
        qbits = (is8 ? 5'd16 : 5'd15) + {1'b0, qp_div};

        // forward quantization on the magnitude
        neg   = coef[CW-1];
        absc  = neg ? (~{coef[CW-1], coef} + 1'b1) : {coef[CW-1], coef};
        one   = PW'(1) << qbits;
        off   = intra ? (one / 3) : (one / 6);
        prod  = (PW'(absc) * PW'(mf)) + off;
        mag   = LW'(prod >> qbits);
        level = neg ? (~mag + 1'b1) : mag;

        // inverse scaling from the level just produced
        lv_ext = {{(XW-LW){level[LW-1]}}, level};
        v_ext  = {{(XW-6){1'b0}}, vsc};
        scaled = lv_ext * v_ext;
        rnd    = (qp_div == 4'd0) ? XW'(2) : XW'(1);
        if (!is8)
            res = scaled <<< qp_div;
        else if (qp_div >= 4'd2)
            res = scaled <<< (qp_div - 4'd2);
        else
            res = (scaled + rnd) >>> ((qp_div == 4'd0) ? 4'd2 : 4'd1);
        dq = DW'(res);
    end
endmodule

// File: rtl/quantdq.sv
module quantdq
    import qd_pkg::*;
#(
    parameter int CW  = 16,
    parameter int LW  = 16,
    parameter int DW  = 32,
    parameter int QPW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_sop,
    input  logic [QPW-1:0]         in_qp,
    input  logic                   in_is8x8,
    input  logic                   in_intra,
    input  logic [QD_LANES*CW-1:0] in_coef,
    output logic                   lvl_valid,
    input  logic                   lvl_ready,
    output logic [QD_LANES*LW-1:0] lvl_data,
    output logic                   dq_valid,
    input  logic                   dq_ready,
    output logic [QD_LANES*DW-1:0] dq_data
);
    localparam int LANES = QD_LANES;
    localparam int BW    = $clog2(LANES);

    typedef struct packed {
        logic                   lvl_vld;
        logic                   dq_vld;
        logic [LANES*LW-1:0]    lvl;
        logic [LANES*DW-1:0]    dq;
        logic [BW-1:0]          beat;
        logic [QPW-1:0]         qp;
        logic                   is8;
        logic                   intra;
    } qd_state_t;

    qd_state_t st_d, st_q;

    logic                  lvl_hold, dq_hold, accept, last_beat;
    logic [BW-1:0]         beat_eff;
    logic [QPW-1:0]        qp_eff;
    logic                  is8_eff, intra_eff;
    logic [3:0]            qp_div;
    logic [2:0]            qp_mod;
    logic [LANES*LW-1:0]   lane_lvl;
    logic [LANES*DW-1:0]   lane_dq;

    // block settings: taken live on the first beat, from the latch afterwards
    always_comb begin
        beat_eff  = in_sop ? '0       : st_q.beat;
        qp_eff    = in_sop ? in_qp    : st_q.qp;
        is8_eff   = in_sop ? in_is8x8 : st_q.is8;
        intra_eff = in_sop ? in_intra : st_q.intra;
    end

    qd_qp_split #(.QPW(QPW)) u_split (
        .qp     (qp_eff),
        .qp_div (qp_div),
        .qp_mod (qp_mod)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [2:0] row, col;
        always_comb begin
            row = is8_eff ? 3'(beat_eff) : (3'({beat_eff[0], 1'b0}) + 3'(l / 4));
            col = is8_eff ? 3'(l)        : 3'(l % 4);
        end
        qd_lane #(.CW(CW), .LW(LW), .DW(DW)) u_lane (
            .coef   (in_coef[l*CW +: CW]),
            .row    (row),
            .col    (col),
            .is8    (is8_eff),
            .intra  (intra_eff),
            .qp_div (qp_div),
            .qp_mod (qp_mod),
            .level  (lane_lvl[l*LW +: LW]),
            .dq     (lane_dq[l*DW +: DW])
        );
    end

    always_comb begin
        lvl_hold  = st_q.lvl_vld && !lvl_ready;
        dq_hold   = st_q.dq_vld  && !dq_ready;
        in_ready  = !lvl_hold && !dq_hold;
        accept    = in_valid && in_ready;
        last_beat = is8_eff ? (beat_eff == BW'(LANES - 1)) : (beat_eff == BW'(1));

        st_d = st_q;
        if (st_q.lvl_vld && lvl_ready) st_d.lvl_vld = 1'b0;
        if (st_q.dq_vld  && dq_ready)  st_d.dq_vld  = 1'b0;
        if (accept) begin
            st_d.lvl_vld = 1'b1;
            st_d.dq_vld  = 1'b1;
            st_d.lvl     = lane_lvl;
            st_d.dq      = lane_dq;
            st_d.beat    = last_beat ? '0 : beat_eff + 1'b1;
            st_d.qp      = qp_eff;
            st_d.is8     = is8_eff;
            st_d.intra   = intra_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_valid = st_q.lvl_vld;
    assign lvl_data  = st_q.lvl;
    assign dq_valid  = st_q.dq_vld;
    assign dq_data   = st_q.dq;

endmodule

// File: rtl/quantdq_chk.sv
module quantdq_chk #(
    parameter int LANES = 8,
    parameter int LW    = 16,
    parameter int DW    = 32,
    parameter int QPW   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [QPW-1:0]      in_qp,
    input logic                lvl_valid,
    input logic                lvl_ready,
    input logic [LANES*LW-1:0] lvl_data,
    input logic                dq_valid,
    input logic                dq_ready,
    input logic [LANES*DW-1:0] dq_data
);
    p_qp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_qp <= QPW'(51)));

    p_both_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (lvl_valid && dq_valid));

    p_lvl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_valid && !lvl_ready) |=> (lvl_valid && $stable(lvl_data)));

    p_dq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && !dq_ready) |=> (dq_valid && $stable(dq_data)));

    p_backpress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_valid && !lvl_ready) || (dq_valid && !dq_ready)) |-> !in_ready);

    for (genvar l = 0; l < LANES; l++) begin : g_sign
        logic [LW-1:0] lv;
        logic [DW-1:0] dv;
        assign lv = lvl_data[l*LW +: LW];
        assign dv = dq_data[l*DW +: DW];
        p_sign_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_valid && dq_valid) |->
                (((lv == '0) == (dv == '0)) && ((lv == '0) || (lv[LW-1] == dv[DW-1]))));
    end
endmodule

bind quantdq quantdq_chk #(.LANES(LANES), .LW(LW), .DW(DW), .QPW(QPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_qp     (in_qp),
    .lvl_valid (lvl_valid),
    .lvl_ready (lvl_ready),
    .lvl_data  (lvl_data),
    .dq_valid  (dq_valid),
    .dq_ready  (dq_ready),
    .dq_data   (dq_data)
);

// File: tb/quantdq_tb.sv
`timescale 1ns/1ps
module quantdq_tb;
    localparam int CW = 16, LW = 16, DW = 32, QPW = 6, NL = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, in_sop = 1'b0, in_is8x8 = 1'b0, in_intra = 1'b0;
    logic [QPW-1:0]    in_qp = '0;
    logic [NL*CW-1:0]  in_coef = '0;
    logic              in_ready, lvl_valid, dq_valid;
    logic              lvl_ready = 1'b1, dq_ready = 1'b1;
    logic [NL*LW-1:0]  lvl_data;
    logic [NL*DW-1:0]  dq_data;

    int checks = 0, errors = 0;
    int rdy_mode = 0;
    bit done = 0;

    logic [NL*LW-1:0] q_lvl [$];
    logic [NL*DW-1:0] q_dq  [$];
    bit               q_is8 [$];

    int MF4 [6][3] = '{'{13107,5243,8066},'{11916,4660,7490},'{10082,4194,6554},
                       '{9362,3647,5825},'{8192,3355,5243},'{7282,2893,4559}};
    int V4  [6][3] = '{'{10,16,13},'{11,18,14},'{13,20,16},'{14,23,18},'{16,25,20},'{18,29,23}};
    int MF8 [6][6] = '{'{13107,11428,20972,12222,16777,15481},
                       '{11916,10826,19174,11058,14980,14290},
                       '{10082,8943,15978,9675,12710,11985},
                       '{9362,8228,14913,8931,11984,11259},
                       '{8192,7346,13159,7740,10486,9777},
                       '{7282,6428,11570,6830,9118,8640}};
    int V8  [6][6] = '{'{20,18,32,19,25,24},'{22,19,35,21,28,26},'{26,23,42,24,33,31},
                       '{28,25,45,26,35,33},'{32,28,51,30,40,38},'{36,32,58,34,46,43}};

    quantdq #(.CW(CW), .LW(LW), .DW(DW), .QPW(QPW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_qp(in_qp), .in_is8x8(in_is8x8), .in_intra(in_intra),
        .in_coef(in_coef), .lvl_valid(lvl_valid), .lvl_ready(lvl_ready),
        .lvl_data(lvl_data), .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_data(dq_data)
    );

    always #2.5 clk = ~clk;

    // R2: position class per requirement text
    function automatic int cls_of(bit is8, int r, int c);
        if (!is8) begin
            if (r % 2 == 0 && c % 2 == 0) return 0;
            if (r % 2 == 1 && c % 2 == 1) return 1;
            return 2;
        end
        if (r % 4 == 0 && c % 4 == 0) return 0;
        if (r % 2 == 1 && c % 2 == 1) return 1;
        if (r % 4 == 2 && c % 4 == 2) return 2;
        if ((r % 4 == 0 && c % 2 == 1) || (r % 2 == 1 && c % 4 == 0)) return 3;
        if ((r % 4 == 0 && c % 4 == 2) || (r % 4 == 2 && c % 4 == 0)) return 4;
        return 5;
    endfunction

    // R4
    function automatic longint ref_lvl(int c, int qp, bit is8, bit intra, int r, int col);
        longint a, mf, one, off, mag;
        int qb, k;
        k   = cls_of(is8, r, col);
        mf  = is8 ? MF8[qp % 6][k] : MF4[qp % 6][k];
        qb  = (is8 ? 16 : 15) + qp / 6;
        a   = (c < 0) ? -c : c;
        one = longint'(1) << qb;
        off = intra ? one / 3 : one / 6;
        mag = (a * mf + off) >> qb;
        return (c < 0) ? -mag : mag;
    endfunction

    // R5, R6
    function automatic longint ref_dq(longint lv, int qp, bit is8, int r, int col);
        longint s;
        int k, q6;
        k  = cls_of(is8, r, col);
        q6 = qp / 6;
        s  = lv * (is8 ? V8[qp % 6][k] : V4[qp % 6][k]);
        if (!is8)         return s <<< q6;
        else if (q6 >= 2) return s <<< (q6 - 2);
        else if (q6 == 0) return (s + 2) >>> 2;
        else              return (s + 1) >>> 1;
    endfunction

    function automatic int gen(int pat, int b, int l);
        case (pat)
            0: return (b * 8 + l) * 97 - 3000;
            1: return (((l + b) % 2) != 0 ? -1 : 1) * (200 + 53 * l + 311 * b);
            2: return (l % 2) != 0 ? -32768 : 32767;
            3: return 0;
            4: return int'($urandom % 8001) - 4000;
            default: return int'($urandom % 7) - 3;
        endcase
    endfunction

    task automatic send_block(int qp, bit is8, bit intra, int pat);
        int nb;
        nb = is8 ? 8 : 2;
        for (int b = 0; b < nb; b++) begin
            logic [NL*LW-1:0] el;
            logic [NL*DW-1:0] ed;
            for (int l = 0; l < NL; l++) begin
                int c, r, col;
                longint lv;
                c   = gen(pat, b, l);
                r   = is8 ? b : 2 * b + l / 4;   // R3 layout
                col = is8 ? l : l % 4;
                in_coef[l*CW +: CW] = CW'(c);
                lv  = ref_lvl(c, qp, is8, intra, r, col);
                el[l*LW +: LW] = LW'(lv);
                ed[l*DW +: DW] = DW'(ref_dq(lv, qp, is8, r, col));
            end
            // R7: later beats carry conflicting settings that must be ignored
            in_sop   = (b == 0);
            in_qp    = (b == 0) ? QPW'(qp) : QPW'($urandom % 52);
            in_is8x8 = (b == 0) ? is8 : ~is8;
            in_intra = (b == 0) ? intra : ~intra;
            in_valid = 1'b1;
            do @(negedge clk); while (!in_ready);
            q_lvl.push_back(el);
            q_dq.push_back(ed);
            q_is8.push_back(is8);
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_sop   = 1'b0;
        end
    endtask

    // ready generators
    initial begin
        forever begin
            @(posedge clk); #1;
            case (rdy_mode)
                0: begin lvl_ready = 1'b1; dq_ready = 1'b1; end
                1: begin lvl_ready = ($urandom % 10) < 7; dq_ready = ($urandom % 10) < 6; end
                2: begin lvl_ready = 1'b1; dq_ready = 1'b0; end
                default: begin lvl_ready = 1'b0; dq_ready = 1'b1; end
            endcase
        end
    end

    // monitor and scoreboard
    bit               lvl_held = 0, dq_held = 0;
    logic [NL*LW-1:0] lvl_prev;
    logic [NL*DW-1:0] dq_prev;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (lvl_held) begin
                    checks++;
                    if (!lvl_valid || lvl_data !== lvl_prev) begin
                        errors++;
                        $display("FAIL R9 level beat changed under stall: got %h exp %h", lvl_data, lvl_prev);
                    end
                end
                if (dq_held) begin
                    checks++;
                    if (!dq_valid || dq_data !== dq_prev) begin
                        errors++;
                        $display("FAIL R9 dequant beat changed under stall: got %h exp %h", dq_data, dq_prev);
                    end
                end
                if ((lvl_valid && !lvl_ready) || (dq_valid && !dq_ready)) begin
                    checks++;
                    if (in_ready !== 1'b0) begin
                        errors++;
                        $display("FAIL R10 in_ready got %b exp 0 while an output stalls", in_ready);
                    end
                end
                if (lvl_valid && dq_valid) begin
                    bit bad;
                    bad = 0;
                    for (int l = 0; l < NL; l++) begin
                        logic [LW-1:0] a;
                        logic [DW-1:0] d;
                        a = lvl_data[l*LW +: LW];
                        d = dq_data[l*DW +: DW];
                        if (((a == 0) != (d == 0)) || (a != 0 && a[LW-1] != d[DW-1])) bad = 1;
                    end
                    checks++;
                    if (bad) begin
                        errors++;
                        $display("FAIL R11 sign mismatch: lvl %h dq %h", lvl_data, dq_data);
                    end
                end
                if (lvl_valid && lvl_ready) begin
                    checks++;
                    if (q_lvl.size() == 0) begin
                        errors++;
                        $display("FAIL R8 unexpected level beat %h exp none", lvl_data);
                    end else begin
                        logic [NL*LW-1:0] e;
                        e = q_lvl.pop_front();
                        if (lvl_data !== e) begin
                            errors++;
                            $display("FAIL R4 levels got %h exp %h", lvl_data, e);
                        end
                    end
                end
                if (dq_valid && dq_ready) begin
                    checks++;
                    if (q_dq.size() == 0) begin
                        errors++;
                        $display("FAIL R8 unexpected dequant beat %h exp none", dq_data);
                    end else begin
                        logic [NL*DW-1:0] e;
                        bit s8;
                        e  = q_dq.pop_front();
                        s8 = q_is8.pop_front();
                        if (dq_data !== e) begin
                            errors++;
                            $display("FAIL %s dequant got %h exp %h", s8 ? "R6" : "R5", dq_data, e);
                        end
                    end
                end
                lvl_held = lvl_valid && !lvl_ready;
                dq_held  = dq_valid && !dq_ready;
                lvl_prev = lvl_data;
                dq_prev  = dq_data;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog expired, got hang exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (lvl_valid !== 1'b0 || dq_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 valid in reset got %b%b exp 00", lvl_valid, dq_valid);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (lvl_valid !== 1'b0 || dq_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 after reset got %b%b%b exp 001", lvl_valid, dq_valid, in_ready);
        end
        @(posedge clk); #1;

        // directed blocks, consumers always ready
        send_block(28, 0, 1, 0);   // R3 R4 R5 4x4 ramp
        send_block(0,  0, 0, 1);   // R4 inter offset, qp 0
        send_block(5,  1, 1, 0);   // R6 small-qp right shift, qp/6 = 0
        send_block(11, 1, 0, 1);   // R6 qp/6 = 1
        send_block(12, 1, 1, 4);   // R6 boundary qp/6 = 2
        send_block(51, 1, 1, 2);   // R4 extremes, top qp
        send_block(51, 0, 0, 2);
        send_block(30, 1, 0, 3);   // R4 zero stays zero
        send_block(6,  0, 1, 5);   // R4 small values near rounding
        send_block(34, 0, 1, 4);   // R2 doubling against qp 28 block

        // random back-pressure on both streams
        rdy_mode = 1;
        for (int i = 0; i < 24; i++)
            send_block(int'($urandom % 52), 1'($urandom % 2), 1'($urandom % 2), 4);

        // R10: hold one consumer, then the other
        rdy_mode = 2;
        fork
            send_block(20, 1, 1, 0);
            begin repeat (30) @(posedge clk); rdy_mode = 3; repeat (30) @(posedge clk); rdy_mode = 0; end
        join
        rdy_mode = 0;
        send_block(40, 0, 0, 1);

        while (q_lvl.size() != 0 || q_dq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule